// File: doc/BRIEF.md
# Replayed-Program Shared-ALU Sequencer

This block computes a whole dataflow graph with one arithmetic/logic unit. Each node of the graph becomes one stored control word. A program counter reads these words one after another and applies them to the unit. Each word names two operand slots in a small register-file-style data memory, the operation to apply and the slot that receives the result. All intermediate values live in that shared data memory, so no register belongs to any one operator. The schedule is held in memory, so the same hardware runs any graph that fits in the stored words and the data slots.

In use, the host first writes the program into the instruction memory and the operands into the data memory through the load port. It then pulses `start` and waits for `done`. While the block is idle it reads the results back through the result port. One control word retires per clock. A word with its stop flag set completes the program.

Top module: `vseq_core`

## Requirements
- R1: After synchronous reset the block is idle with `done` low, and the first `start` begins execution at control word 0.
- R2: A control word is 17 bits: bit 16 is the stop flag, bits 15:12 the operation, bits 11:8 operand slot P, bits 7:4 operand slot Q, bits 3:0 the destination slot.
- R3: Operation codes: 0 gives P+Q, 1 gives P−Q, 2 gives P AND Q, 3 gives P OR Q, 4 gives P XOR Q, 5 gives the low 16 bits of P·Q, 6 passes P, 7 gives NOT P, and codes 8 to 15 give 0. All results are taken modulo 2^16.
- R4: After `start`, exactly one control word retires per clock, in address order from word 0.
- R5: A result written by one control word is seen by the operand reads of the very next word. This also holds when a slot is both read and written.
- R6: The word with the stop flag still writes its result. `done` rises h+1 clock edges after the edge that samples `start`, where h is that word's address. `done` then stays high until the next accepted `start`.
- R7: After the stop word, no further words execute and the data memory holds its contents, however long the block stays idle.
- R8: A `start` pulse while a program is running has no effect on the results or on the time at which it finishes.
- R9: Writes from the load port to either memory are ignored while a program is running.
- R10: A five-word program (x·x, A·x², B·x and two additions) leaves y = A·x² + B·x + C (mod 2^16) in its destination slot.
- R11: A `start` while `done` is high clears `done` on that edge and reruns the program from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin running the stored program at word 0 |
| done | output | 1 | High from the retirement of the stop word until the next start |
| imem_ld_we | input | 1 | Write strobe for the instruction memory (honoured only while idle) |
| imem_ld_addr | input | 4 | Instruction memory address to write |
| imem_ld_word | input | 17 | Control word to write |
| dmem_ld_we | input | 1 | Write strobe for the data memory (honoured only while idle) |
| dmem_ld_addr | input | 4 | Data slot to write |
| dmem_ld_data | input | 16 | Value to write |
| res_addr | input | 4 | Data slot to read back while idle |
| res_data | output | 16 | Contents of slot `res_addr` while idle (undefined while running) |

## Verification
An operator sweep applies all eight operations and one unused code to a single operand pair. The pair is chosen so that subtraction wraps and multiplication overflows, which separates each operation and detects a mis-decoded code. A chain of doubling words and a repeated in-place accumulation show whether a result reaches the next word's reads, and the finish time tells an off-by-one sequencer apart. Stray `start` and load pulses during a run, a stop word followed by an overwriting word, a stop at word 0, and the quadratic run with a small and an overflowing x cover freezing, ignored inputs and rerun behaviour.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    localparam int DW    = 16;
    localparam int RAW   = 4;
    localparam int IAW   = 4;
    localparam int OPW   = 4;
    localparam int NREG  = 1 << RAW;
    localparam int NINST = 1 << IAW;
    localparam int IW    = 1 + OPW + 3 * RAW;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_MUL  = 4'd5,
        OP_PASS = 4'd6,
        OP_NOT  = 4'd7
    } op_e;

    typedef struct packed {
        logic           stop;
        logic [OPW-1:0] op;
        logic [RAW-1:0] src_p;
        logic [RAW-1:0] src_q;
        logic [RAW-1:0] dst;
    } ctl_word_t;

    function automatic logic [DW-1:0] alu_eval(input logic [OPW-1:0] op,
                                               input logic [DW-1:0]  p,
                                               input logic [DW-1:0]  q);
        logic [2*DW-1:0] prod;
        prod = p * q;
        case (op)
            OP_ADD:  alu_eval = p + q;
            OP_SUB:  alu_eval = p - q;
            OP_AND:  alu_eval = p & q;
            OP_OR:   alu_eval = p | q;
            OP_XOR:  alu_eval = p ^ q;
            OP_MUL:  alu_eval = prod[DW-1:0];
            OP_PASS: alu_eval = p;
            OP_NOT:  alu_eval = ~p;
            default: alu_eval = '0;
        endcase
    endfunction

endpackage

// File: rtl/vseq_imem.sv
module vseq_imem #(
    parameter int AW = 4,
    parameter int WW = 17
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/vseq_rf.sv
module vseq_rf #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_p,
    output logic [DW-1:0] rdata_p,
    input  logic [AW-1:0] raddr_q,
    output logic [DW-1:0] rdata_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slot[waddr] <= wdata;
    end

    assign rdata_p = slot[raddr_p];
    assign rdata_q = slot[raddr_q];

    // R5
    wb_visible_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (raddr_p != $past(waddr) || rdata_p == $past(wdata)));
endmodule

// File: rtl/vseq_alu.sv
module vseq_alu
    import vseq_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  p,
    input  logic [DW-1:0]  q,
    output logic [DW-1:0]  y
);
    always_comb y = alu_eval(op, p, q);
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    output logic [AW-1:0] pc,
    output logic          running,
    output logic          done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else if (!running) begin
            if (start) begin
                pc      <= '0;
                running <= 1'b1;
                done    <= 1'b0;
            end
        end else if (stop) begin
            running <= 1'b0;
            done    <= 1'b1;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !stop) |=> (pc == AW'($past(pc) + 1'b1)));

    // R6
    done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(running && stop));

    // R7
    pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> $stable(pc));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !running);
endmodule

// File: rtl/vseq_core.sv
module vseq_core
    import vseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    output logic           done,
    input  logic           imem_ld_we,
    input  logic [IAW-1:0] imem_ld_addr,
    input  logic [IW-1:0]  imem_ld_word,
    input  logic           dmem_ld_we,
    input  logic [RAW-1:0] dmem_ld_addr,
    input  logic [DW-1:0]  dmem_ld_data,
    input  logic [RAW-1:0] res_addr,
    output logic [DW-1:0]  res_data
);
    logic [IAW-1:0] pc;
    logic           running;
    logic [IW-1:0]  raw_word;
    ctl_word_t      cw;
    logic [DW-1:0]  opnd_p, opnd_q, alu_y;
    logic [RAW-1:0] rd_p_addr;
    logic           rf_we;
    logic [RAW-1:0] rf_waddr;
    logic [DW-1:0]  rf_wdata;

    vseq_ctrl #(.AW(IAW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .stop(cw.stop),
        .pc(pc), .running(running), .done(done)
    );

    vseq_imem #(.AW(IAW), .WW(IW)) u_imem (
        .clk(clk), .we(imem_ld_we && !running), .waddr(imem_ld_addr),
        .wdata(imem_ld_word), .raddr(pc), .rdata(raw_word)
    );

    assign cw = ctl_word_t'(raw_word);

    // Port P doubles as the result read port while idle.
    always_comb begin
        rd_p_addr = running ? cw.src_p : res_addr;
        if (running) begin
            rf_we    = 1'b1;
            rf_waddr = cw.dst;
            rf_wdata = alu_y;
        end else begin
            rf_we    = dmem_ld_we;
            rf_waddr = dmem_ld_addr;
            rf_wdata = dmem_ld_data;
        end
    end

    vseq_rf #(.AW(RAW), .DW(DW)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .raddr_p(rd_p_addr), .rdata_p(opnd_p),
        .raddr_q(cw.src_q), .rdata_q(opnd_q)
    );

    vseq_alu u_alu (.op(cw.op), .p(opnd_p), .q(opnd_q), .y(alu_y));

    assign res_data = opnd_p;
endmodule

// File: tb/test_vseq_core.sv
module test_vseq_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        done;
    logic        imem_ld_we = 1'b0;
    logic [3:0]  imem_ld_addr = '0;
    logic [16:0] imem_ld_word = '0;
    logic        dmem_ld_we = 1'b0;
    logic [3:0]  dmem_ld_addr = '0;
    logic [15:0] dmem_ld_data = '0;
    logic [3:0]  res_addr = '0;
    logic [15:0] res_data;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    vseq_core i_vseq_core (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_word(imem_ld_word),
        .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
        .res_addr(res_addr), .res_data(res_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic put_word(input int idx, input bit stop, input int op,
                            input int p, input int q, input int d);
        @(negedge clk);
        imem_ld_we   = 1'b1;
        imem_ld_addr = 4'(idx);
        imem_ld_word = {stop, 4'(op), 4'(p), 4'(q), 4'(d)};
        @(negedge clk);
        imem_ld_we = 1'b0;
    endtask

    task automatic put_data(input int slot, input logic [15:0] v);
        @(negedge clk);
        dmem_ld_we   = 1'b1;
        dmem_ld_addr = 4'(slot);
        dmem_ld_data = v;
        @(negedge clk);
        dmem_ld_we = 1'b0;
    endtask

    task automatic get_data(input int slot, output logic [15:0] v);
        @(negedge clk);
        res_addr = 4'(slot);
        #1 v = res_data;
    endtask

    task automatic check_slot(input string tag, input int slot, input logic [15:0] exp);
        logic [15:0] v;
        get_data(slot, v);
        chk(tag, 32'(v), 32'(exp));
    endtask

    // Pulse start; return number of negedges until done seen high.
    task automatic run(output int cyc);
        @(negedge clk);
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 100);
    endtask

    task automatic t_reset;
        chk("R1 done low after reset", 32'(done), 0);
    endtask

    task automatic t_ops;
        logic [15:0] a = 16'h1234;
        logic [15:0] b = 16'h5A0F;
        logic [31:0] prod;
        int cyc;
        prod = a * b;
        put_data(1, a); put_data(2, b); put_data(11, 16'hFFFF);
        put_word(0, 0, 0, 1, 2, 3);
        put_word(1, 0, 1, 1, 2, 13);
        put_word(2, 0, 2, 1, 2, 4);
        put_word(3, 0, 3, 1, 2, 5);
        put_word(4, 0, 4, 1, 2, 7);
        put_word(5, 0, 5, 1, 2, 8);
        put_word(6, 0, 6, 1, 2, 9);
        put_word(7, 0, 7, 1, 2, 10);
        put_word(8, 1, 11, 1, 2, 11);
        run(cyc);
        chk("R1 R4 R6 op sweep finish cycle", 32'(cyc), 10);
        check_slot("R3 add", 3, a + b);
        check_slot("R3 sub wraps", 13, a - b);
        check_slot("R3 and", 4, a & b);
        check_slot("R3 or", 5, a | b);
        check_slot("R3 xor", 7, a ^ b);
        check_slot("R3 mul low half", 8, prod[15:0]);
        check_slot("R3 pass", 9, a);
        check_slot("R3 not", 10, ~a);
        check_slot("R2 R3 unused code gives zero", 11, 16'h0000);
    endtask

    task automatic t_chain;
        int cyc;
        put_data(1, 16'd1); put_data(6, 16'd5);
        put_word(0, 0, 0, 1, 1, 2);
        put_word(1, 0, 0, 2, 2, 3);
        put_word(2, 0, 0, 3, 3, 4);
        put_word(3, 0, 0, 6, 1, 6);
        put_word(4, 0, 0, 6, 1, 6);
        put_word(5, 1, 0, 4, 4, 5);
        run(cyc);
        chk("R4 R6 chain finish cycle", 32'(cyc), 7);
        check_slot("R5 chain step 2", 3, 16'd4);
        check_slot("R5 chain end", 5, 16'd16);
        check_slot("R5 in-place accumulate", 6, 16'd7);
    endtask

    task automatic t_stop_at_zero;
        int cyc;
        logic [15:0] v;
        put_data(1, 16'd21); put_data(2, 16'h7777); put_data(9, 16'h0000);
        put_word(0, 1, 0, 1, 1, 9);
        put_word(1, 0, 6, 2, 2, 9);
        run(cyc);
        chk("R6 stop at word 0 finish cycle", 32'(cyc), 2);
        repeat (10) @(negedge clk);
        chk("R6 done held high", 32'(done), 1);
        get_data(9, v);
        chk("R6 R7 stop word writes, later word never runs", 32'(v), 32'd42);
        chk("R6 done still high after reads", 32'(done), 1);
    endtask

    task automatic t_stray_start;
        int cyc;
        put_data(1, 16'd1); put_data(6, 16'd0);
        for (int i = 0; i < 5; i++) put_word(i, 0, 0, 6, 1, 6);
        put_word(5, 1, 0, 6, 1, 6);
        @(negedge clk);
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = (cyc == 3);
        end while (!done && cyc < 100);
        start = 1'b0;
        chk("R8 stray start finish cycle", 32'(cyc), 7);
        check_slot("R8 stray start result", 6, 16'd6);
    endtask

    task automatic t_load_during_run;
        int cyc;
        put_data(1, 16'd1); put_data(6, 16'd0); put_data(12, 16'h0055);
        for (int i = 0; i < 3; i++) put_word(i, 0, 0, 6, 1, 6);
        put_word(3, 1, 0, 6, 1, 6);
        put_word(4, 1, 6, 1, 1, 12);
        @(negedge clk);
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (cyc == 2) begin
                dmem_ld_we = 1'b1; dmem_ld_addr = 4'd12; dmem_ld_data = 16'hBEEF;
                imem_ld_we = 1'b1; imem_ld_addr = 4'd3;
                imem_ld_word = {1'b0, 4'd0, 4'd6, 4'd1, 4'd6};
            end else begin
                dmem_ld_we = 1'b0; imem_ld_we = 1'b0;
            end
        end while (!done && cyc < 100);
        dmem_ld_we = 1'b0; imem_ld_we = 1'b0;
        chk("R9 program word load ignored, finish cycle", 32'(cyc), 5);
        check_slot("R9 accumulate result", 6, 16'd4);
        check_slot("R9 data load ignored", 12, 16'h0055);
    endtask

    task automatic t_quad(input logic [15:0] x, input logic [15:0] ka,
                          input logic [15:0] kb, input logic [15:0] kc, input bit rerun);
        int cyc;
        logic [15:0] y;
        y = ka * x * x + kb * x + kc;
        put_data(0, x); put_data(1, ka); put_data(2, kb); put_data(3, kc);
        put_word(0, 0, 5, 0, 0, 4);
        put_word(1, 0, 5, 1, 4, 5);
        put_word(2, 0, 5, 2, 0, 6);
        put_word(3, 0, 0, 5, 6, 7);
        put_word(4, 1, 0, 7, 3, 8);
        run(cyc);
        chk("R10 quadratic finish cycle", 32'(cyc), 6);
        check_slot("R10 quadratic result", 8, y);
        if (rerun) begin
            put_data(8, 16'h0000);
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R11 done cleared by restart", 32'(done), 0);
            cyc = 1;
            while (!done && cyc < 100) begin
                @(negedge clk);
                cyc++;
            end
            chk("R11 rerun finish cycle", 32'(cyc), 6);
            check_slot("R11 rerun result", 8, y);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ops();
        t_chain();
        t_stop_at_zero();
        t_stray_start();
        t_load_during_run();
        t_quad(16'd3, 16'd2, 16'd5, 16'd7, 1'b0);
        t_quad(16'd300, 16'd1000, 16'hFFF0, 16'd9, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule